// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside the fetch sequencer of a 32-bit processor and decides, at the first step of every instruction fetch, whether an external interrupt request is taken instead of the normal fetch. There are no priority levels. A single enable flag gates every request. When a request is taken, the block does four things in that same step:

- It records the interrupted program counter in a saved-PC register.
- It captures the 16-bit cause word supplied by the source.
- It clears the enable flag.
- It hands the sequencer a handler address and a load strobe.

The handler address is formed from the source's 8-bit type code.

The block also performs the state changes of the interrupt-support instructions. Each is presented to it as an opcode strobe together with up to two register operands:

- Return: restores the PC and re-enables interrupts as one indivisible action.
- Enable and disable: set or clear the enable flag.
- Save: exposes the saved cause and saved PC so that they can be written to registers.
- Restore: reloads the saved cause and saved PC from registers.

Any resolution between several requesting sources is done outside the block, and only its winner is presented.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After synchronous reset the enable flag (`int_en`) is 0, the saved PC and saved cause are 0, and `pc_load` and `irq_ack` are low.
- R2: A request is taken only in a cycle where `fetch_start`, `irq_req` and the enable flag are all 1. In that cycle `pc_load` is 1 and `pc_next` equals the source code placed at bits 11..4, with bits 31..12 and 3..0 zero.
- R3: On the clock edge that ends a taken cycle, the saved PC receives `cur_pc`, the saved cause receives `src_info`, and the enable flag becomes 0.
- R4: `irq_ack` is high exactly in the cycle a request is taken, and low in the following cycle.
- R5: In a `fetch_start` cycle where no request is taken, `pc_load` stays low.
- R6: Opcode 29 (return) drives `pc_load` high with `pc_next` equal to the saved PC, and the enable flag is 1 from the next edge on.
- R7: Opcode 10 sets the enable flag and opcode 11 clears it, effective from the next edge.
- R8: Opcode 16 (save) raises `save_valid` for that cycle. In that cycle `save_info` carries the saved cause in bits 15..0 with zeros above, and `save_pc` carries the saved PC.
- R9: Opcode 17 (restore) loads the saved cause from `opnd_a` bits 15..0 and the saved PC from `opnd_b`, effective from the next edge.
- R10: Any other opcode, and any opcode presented with `op_valid` low, changes no state and leaves `pc_load` low.
- R11: An opcode strobe that coincides with `fetch_start` is ignored: it changes no state and does not load the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_start | input | 1 | First step of an instruction fetch |
| irq_req | input | 1 | Interrupt request from the external source |
| src_vec | input | 8 | Source type code used to form the handler address |
| src_info | input | 16 | Source cause word |
| cur_pc | input | 32 | Program counter at the fetch step |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 5 | Opcode of the current instruction |
| opnd_a | input | 32 | First register operand (cause for restore) |
| opnd_b | input | 32 | Second register operand (PC for restore) |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 32 | New program counter value |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| int_en | output | 1 | Current enable flag |
| save_valid | output | 1 | Save instruction is active this cycle |
| save_info | output | 32 | Saved cause, zero-extended |
| save_pc | output | 32 | Saved PC |

## Verification
The hardest situation to reach is a request that stays high across the entry step and into the next fetch. It must not be taken a second time, because the entry itself closed the enable flag. The stimulus reaches it by enabling interrupts, taking one request, and holding the request line high through a further fetch step. The saved registers are then read back through the save instruction, and the pair is returned with opcode 29. The other delicate case is an opcode strobe that collides with a fetch step. It is driven while the flag is set, and the flag is then checked to confirm it did not move.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int XLEN     = 32;
    localparam int INFO_W   = 16;
    localparam int SRC_W    = 8;
    localparam int VEC_LSB  = 4;
    localparam int OPC_W    = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_INT_ON   = 5'd10,
        OPC_INT_OFF  = 5'd11,
        OPC_SAVE     = 5'd16,
        OPC_RESTORE  = 5'd17,
        OPC_RETURN   = 5'd29
    } irq_opc_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic save;
        logic restore;
        logic ret;
    } irq_cmd_t;

    localparam irq_cmd_t CMD_NONE = '{default: 1'b0};

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_start,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    output irq_cmd_t         cmd
);

    // An opcode strobe is only honoured outside fetch steps.
    logic live;
    assign live = op_valid && !fetch_start;

    always_comb begin
        cmd = CMD_NONE;
        if (live) begin
            unique case (opcode)
                OPC_INT_ON:  cmd.set_en  = 1'b1;
                OPC_INT_OFF: cmd.clr_en  = 1'b1;
                OPC_SAVE:    cmd.save    = 1'b1;
                OPC_RESTORE: cmd.restore = 1'b1;
                OPC_RETURN:  cmd.ret     = 1'b1;
                default:     cmd = CMD_NONE;
            endcase
        end
    end

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones(cmd) <= 1);                                   // R10

    AST_FETCH_MUTES_CMD: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> (cmd == CMD_NONE));                      // R11

endmodule

// File: rtl/irq_take_unit.sv
module irq_take_unit #(
    parameter int DATA_W  = irq_entry_pkg::XLEN,
    parameter int SRC_W   = irq_entry_pkg::SRC_W,
    parameter int VEC_LSB = irq_entry_pkg::VEC_LSB
) (
    input  logic              fetch_start,
    input  logic              irq_req,
    input  logic              int_en,
    input  logic [SRC_W-1:0]  src_vec,
    output logic              take,
    output logic [DATA_W-1:0] vector
);

    localparam int VEC_MSB = VEC_LSB + SRC_W - 1;

    initial begin
        if (VEC_MSB >= DATA_W)
            $error("source code field does not fit the address width");
    end

    assign take = fetch_start && irq_req && int_en;

    // The source code sits in a fixed field; all other bits are zero.
    always_comb begin
        vector = '0;
        vector[VEC_MSB:VEC_LSB] = src_vec;
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int INFO_W = irq_entry_pkg::INFO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  irq_cmd_t          cmd,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [INFO_W-1:0] src_info,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              int_en,
    output logic [DATA_W-1:0] saved_pc,
    output logic [INFO_W-1:0] saved_info
);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_en     <= 1'b0;
            saved_pc   <= '0;
            saved_info <= '0;
        end else if (take) begin
            int_en     <= 1'b0;
            saved_pc   <= cur_pc;
            saved_info <= src_info;
        end else begin
            if (cmd.set_en || cmd.ret) int_en <= 1'b1;
            if (cmd.clr_en)            int_en <= 1'b0;
            if (cmd.restore) begin
                saved_info <= opnd_a[INFO_W-1:0];
                saved_pc   <= opnd_b;
            end
        end
    end

    AST_TAKE_CLOSES_EN: assert property (@(posedge clk) disable iff (rst)
        take |=> !int_en);                                       // R3

    AST_TAKE_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
        take |=> (saved_pc == $past(cur_pc)));                   // R3

    AST_TAKE_SAVES_INFO: assert property (@(posedge clk) disable iff (rst)
        take |=> (saved_info == $past(src_info)));               // R3

    AST_RETURN_OPENS_EN: assert property (@(posedge clk) disable iff (rst)
        cmd.ret |=> int_en);                                     // R6

    AST_OFF_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        cmd.clr_en |=> !int_en);                                 // R7

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (!take && cmd == CMD_NONE) |=>
            ($stable(int_en) && $stable(saved_pc) && $stable(saved_info))); // R10

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_start,
    input  logic                 irq_req,
    input  logic [SRC_W-1:0]     src_vec,
    input  logic [INFO_W-1:0]    src_info,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic                 op_valid,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    output logic                 pc_load,
    output logic [XLEN-1:0]      pc_next,
    output logic                 irq_ack,
    output logic                 int_en,
    output logic                 save_valid,
    output logic [XLEN-1:0]      save_info,
    output logic [XLEN-1:0]      save_pc
);

    irq_cmd_t          cmd;
    logic              take;
    logic [XLEN-1:0]   vector;
    logic [XLEN-1:0]   saved_pc;
    logic [INFO_W-1:0] saved_info;

    irq_cmd_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .fetch_start (fetch_start),
        .op_valid    (op_valid),
        .opcode      (opcode),
        .cmd         (cmd)
    );

    irq_take_unit #(
        .DATA_W  (XLEN),
        .SRC_W   (SRC_W),
        .VEC_LSB (VEC_LSB)
    ) u_take (
        .fetch_start (fetch_start),
        .irq_req     (irq_req),
        .int_en      (int_en),
        .src_vec     (src_vec),
        .take        (take),
        .vector      (vector)
    );

    irq_state_regs #(
        .DATA_W (XLEN),
        .INFO_W (INFO_W)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .cmd        (cmd),
        .cur_pc     (cur_pc),
        .src_info   (src_info),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .int_en     (int_en),
        .saved_pc   (saved_pc),
        .saved_info (saved_info)
    );

    assign irq_ack    = take;
    assign pc_load    = take || cmd.ret;
    assign save_valid = cmd.save;
    assign save_pc    = saved_pc;

    always_comb begin
        save_info = '0;
        save_info[INFO_W-1:0] = saved_info;
    end

    always_comb begin
        if (take)         pc_next = vector;
        else if (cmd.ret) pc_next = saved_pc;
        else              pc_next = '0;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);                                   // R4

    AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (irq_ack || (op_valid && opcode == OPC_RETURN))); // R5

    AST_ACK_NEEDS_FETCH: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (fetch_start && irq_req));                   // R2

    AST_ACK_ADDR_FIELD: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (pc_next[3:0] == 4'h0 && pc_next[XLEN-1:12] == '0)); // R2

    AST_FETCH_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && !irq_ack) |=> $stable(int_en));          // R11

endmodule

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_start;
    logic        irq_req;
    logic [7:0]  src_vec;
    logic [15:0] src_info;
    logic [31:0] cur_pc;
    logic        op_valid;
    logic [4:0]  opcode;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        pc_load;
    logic [31:0] pc_next;
    logic        irq_ack;
    logic        int_en;
    logic        save_valid;
    logic [31:0] save_info;
    logic [31:0] save_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .fetch_start(fetch_start), .irq_req(irq_req),
        .src_vec(src_vec), .src_info(src_info), .cur_pc(cur_pc),
        .op_valid(op_valid), .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .pc_load(pc_load), .pc_next(pc_next), .irq_ack(irq_ack), .int_en(int_en),
        .save_valid(save_valid), .save_info(save_info), .save_pc(save_pc)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_start = 1'b0; irq_req = 1'b0; op_valid = 1'b0;
        opcode = 5'd0; opnd_a = '0; opnd_b = '0;
    endtask

    // Inputs change on the falling edge; combinational outputs are read 1 ns later.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic issue(input logic [4:0] opc, input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1; opcode = opc; opnd_a = a; opnd_b = b;
        #1;
    endtask

    task automatic read_saved(input string tag, input logic [31:0] exp_info,
                              input logic [31:0] exp_pc);
        issue(5'd16, '0, '0);
        chk({tag, " save_valid"}, {31'b0, save_valid}, 32'd1);
        chk({tag, " save_info"}, save_info, exp_info);
        chk({tag, " save_pc"}, save_pc, exp_pc);
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_inputs();
        src_vec = '0; src_info = '0; cur_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 int_en", {31'b0, int_en}, 32'd0);
        chk("R1 pc_load", {31'b0, pc_load}, 32'd0);
        chk("R1 irq_ack", {31'b0, irq_ack}, 32'd0);
        read_saved("R1", 32'h0, 32'h0);
    endtask

    task automatic t_blocked_when_off();
        fetch_start = 1'b1; irq_req = 1'b1; src_vec = 8'h33; #1;
        chk("R2 disabled pc_load", {31'b0, pc_load}, 32'd0);
        chk("R5 disabled irq_ack", {31'b0, irq_ack}, 32'd0);
        step();
    endtask

    task automatic t_enable();
        issue(5'd10, '0, '0);
        step();
        chk("R7 enable", {31'b0, int_en}, 32'd1);
    endtask

    task automatic t_take();
        fetch_start = 1'b1; irq_req = 1'b1; src_vec = 8'hA5;
        src_info = 16'hBEEF; cur_pc = 32'h1234_5678; #1;
        chk("R2 take pc_load", {31'b0, pc_load}, 32'd1);
        chk("R2 take pc_next", pc_next, 32'h0000_0A50);
        chk("R4 ack high", {31'b0, irq_ack}, 32'd1);
        step();
        chk("R4 ack released", {31'b0, irq_ack}, 32'd0);
        chk("R3 enable cleared", {31'b0, int_en}, 32'd0);
        // Request still high on the next fetch: must not be taken again.
        fetch_start = 1'b1; irq_req = 1'b1; cur_pc = 32'h0000_0A50; #1;
        chk("R2 no retake", {31'b0, pc_load}, 32'd0);
        step();
        read_saved("R3 R8", 32'h0000_BEEF, 32'h1234_5678);
    endtask

    task automatic t_return();
        issue(5'd29, '0, '0);
        chk("R6 pc_load", {31'b0, pc_load}, 32'd1);
        chk("R6 pc_next", pc_next, 32'h1234_5678);
        step();
        chk("R6 enable set", {31'b0, int_en}, 32'd1);
    endtask

    task automatic t_no_request();
        fetch_start = 1'b1; irq_req = 1'b0; #1;
        chk("R5 no request pc_load", {31'b0, pc_load}, 32'd0);
        step();
        chk("R5 enable kept", {31'b0, int_en}, 32'd1);
    endtask

    task automatic t_fetch_collision();
        fetch_start = 1'b1; irq_req = 1'b0; issue(5'd11, '0, '0);
        chk("R11 collision no load", {31'b0, pc_load}, 32'd0);
        step();
        chk("R11 enable kept", {31'b0, int_en}, 32'd1);
        fetch_start = 1'b1; issue(5'd29, '0, '0);
        chk("R11 return muted", {31'b0, pc_load}, 32'd0);
        step();
    endtask

    task automatic t_edge_vectors();
        fetch_start = 1'b1; irq_req = 1'b1; src_vec = 8'hFF;
        src_info = 16'h0001; cur_pc = 32'hFFFF_FFFC; #1;
        chk("R2 vector all ones", pc_next, 32'h0000_0FF0);
        step();
        issue(5'd29, '0, '0);
        chk("R6 return to top", pc_next, 32'hFFFF_FFFC);
        step();
        fetch_start = 1'b1; irq_req = 1'b1; src_vec = 8'h00; #1;
        chk("R2 vector zero load", {31'b0, pc_load}, 32'd1);
        chk("R2 vector zero", pc_next, 32'h0000_0000);
        step();
    endtask

    task automatic t_disable();
        issue(5'd10, '0, '0); step();
        issue(5'd11, '0, '0); step();
        chk("R7 disable", {31'b0, int_en}, 32'd0);
    endtask

    task automatic t_restore();
        issue(5'd17, 32'hFFFF_1357, 32'hCAFE_0000);
        step();
        read_saved("R9", 32'h0000_1357, 32'hCAFE_0000);
    endtask

    task automatic t_ignored();
        issue(5'd12, 32'h1111_2222, 32'h3333_4444);
        chk("R10 other opcode no load", {31'b0, pc_load}, 32'd0);
        step();
        op_valid = 1'b0; opcode = 5'd29; #1;
        chk("R10 unstrobed return", {31'b0, pc_load}, 32'd0);
        step();
        op_valid = 1'b0; opcode = 5'd10; #1;
        step();
        chk("R10 unstrobed enable", {31'b0, int_en}, 32'd0);
        op_valid = 1'b0; opcode = 5'd17; opnd_a = 32'hAAAA; opnd_b = 32'hBBBB; #1;
        step();
        read_saved("R10", 32'h0000_1357, 32'hCAFE_0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_blocked_when_off();
        t_enable();
        t_take();
        t_return();
        t_no_request();
        t_fetch_collision();
        t_edge_vectors();
        t_disable();
        t_restore();
        t_ignored();
        finish_run();
    end

endmodule